// File: doc/BRIEF.md
# SD card clock generator

This block derives the card bus clock from the system clock. A programmable ratio sits in a mode register. In legacy mode the ratio is always even. In extended mode it is a 9-bit divisor that allows odd ratios, and an odd period splits into a high phase one system clock longer than the low phase. A new ratio is latched only when the card clock rises, so every period is built from one consistent setting. Shortened pulses therefore cannot appear.

Two guard bits can pause the card clock to protect the data buffers. One pauses it while the receive buffer is full. The other pauses it while the transmit buffer is empty. A pause always leaves the card clock low. If a high phase is already under way, it runs to its normal length first.

Single-cycle control strobes enable the block, disable it, or soft-reset it. A soft reset clears the enable and all mode fields, so software must rewrite the mode register afterwards.

Top module: `sdclk_gen`

## Requirements
- R1: After reset, `card_clk` and `clk_active` are 0. The card clock does not toggle until an enable strobe is given.
- R2: In extended mode (`mode_ext`=1), the divisor D is {`mode_div`, `mode_odd`}, with `mode_odd` as bit 0. The card clock period is D+2 system clocks.
- R3: In extended mode, the high phase lasts ceil((D+2)/2) system clocks and the low phase lasts floor((D+2)/2).
- R4: In legacy mode (`mode_ext`=0), the period is 2*(`mode_div`+1) system clocks with equal high and low phases. `mode_odd` has no effect.
- R5: A mode write takes effect only at the next rising edge of the card clock. A period already under way completes with the old ratio.
- R6: With `mode_rd_guard`=1 and `rx_full`=1, the card clock is held low. A high phase already under way completes first. Counting resumes once `rx_full` drops. With `mode_rd_guard`=0, `rx_full` has no effect.
- R7: With `mode_wr_guard`=1 and `tx_empty`=1, the card clock is held low in the same way. With `mode_wr_guard`=0, `tx_empty` has no effect.
- R8: `ctl_en_stb` sets the enable and `ctl_dis_stb` clears it. If both are given in the same cycle, disable wins. While disabled, the clock finishes any high phase and then stays low.
- R9: `ctl_srst_stb` takes priority over every other input. From the next cycle the card clock is low, the block is disabled and all mode fields are 0, so the legacy ratio of 2 applies.
- R10: `clk_active` is 1 exactly when the block is enabled and no enabled guard condition is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_en_stb | input | 1 | Enable strobe |
| ctl_dis_stb | input | 1 | Disable strobe |
| ctl_srst_stb | input | 1 | Soft reset strobe |
| mode_we | input | 1 | Loads the mode fields below |
| mode_div | input | 8 | Divider field (upper divisor bits in extended mode) |
| mode_odd | input | 1 | Divisor bit 0 in extended mode |
| mode_ext | input | 1 | 1 = extended (odd-capable) mode, 0 = legacy |
| mode_rd_guard | input | 1 | Pause the clock while the receive buffer is full |
| mode_wr_guard | input | 1 | Pause the clock while the transmit buffer is empty |
| rx_full | input | 1 | Receive buffer full flag |
| tx_empty | input | 1 | Transmit buffer empty flag |
| card_clk | output | 1 | Card bus clock |
| clk_active | output | 1 | Clock is enabled and not paused |

## Verification
The divider is exercised with several ratios:
- odd extended ratios (9 and the maximum 513), which expose an incorrect high/low split;
- the minimum ratio of 2, which exposes off-by-one counting;
- an even legacy ratio with the odd bit set, which shows whether that bit leaks into legacy mode.

A mode write during a high phase separates correct period-boundary latching from immediate loading.

Guard patterns apply each buffer flag with its guard bit both set and clear. This shows whether a pause is tied to the right flag and whether a disabled guard is ignored.

Strobe patterns cover disabling mid-period, simultaneous enable and disable, and soft reset followed by re-enable without a mode rewrite.

// File: rtl/sdclk_pkg.sv
`timescale 1ns/1ps
package sdclk_pkg;
  localparam int DIV_W = 8;
  localparam int PER_W = DIV_W + 2;

  typedef struct packed {
    logic             ext;
    logic             rd_guard;
    logic             wr_guard;
    logic             odd;
    logic [DIV_W-1:0] div;
  } mode_t;

  // Full card clock period in system clocks.
  function automatic logic [PER_W-1:0] period_of(mode_t m);
    if (m.ext)
      return {1'b0, m.div, m.odd} + PER_W'(2);
    else
      return (PER_W'(m.div) + PER_W'(1)) << 1;
  endfunction

  function automatic logic [PER_W-1:0] high_len(logic [PER_W-1:0] p);
    return (p + PER_W'(1)) >> 1;
  endfunction

  function automatic logic [PER_W-1:0] low_len(logic [PER_W-1:0] p);
    return p >> 1;
  endfunction
endpackage

// File: rtl/sdclk_ctrl.sv
`timescale 1ns/1ps
module sdclk_ctrl
  import sdclk_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  en_stb,
  input  logic  dis_stb,
  input  logic  srst_stb,
  input  logic  mode_we,
  input  mode_t mode_in,
  output logic  en_q,
  output mode_t mode_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      mode_q <= '0;
    end else if (srst_stb) begin
      en_q   <= 1'b0;
      mode_q <= '0;
    end else begin
      if (dis_stb)     en_q <= 1'b0;
      else if (en_stb) en_q <= 1'b1;
      if (mode_we)     mode_q <= mode_in;
    end
  end
endmodule

// File: rtl/sdclk_stall.sv
`timescale 1ns/1ps
module sdclk_stall
  import sdclk_pkg::*;
(
  input  logic  en_q,
  input  mode_t mode_q,
  input  logic  rx_full,
  input  logic  tx_empty,
  output logic  stall,
  output logic  active
);
  localparam int NGUARD = 2;
  logic [NGUARD-1:0] guard_en, guard_cond, guard_hit;

  assign guard_en   = {mode_q.wr_guard, mode_q.rd_guard};
  assign guard_cond = {tx_empty, rx_full};

  for (genvar g = 0; g < NGUARD; g++) begin : g_guard
    assign guard_hit[g] = guard_en[g] & guard_cond[g];
  end

  assign stall  = en_q & (|guard_hit);
  assign active = en_q & ~(|guard_hit);
endmodule

// File: rtl/sdclk_div.sv
`timescale 1ns/1ps
module sdclk_div
  import sdclk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             srst_stb,
  input  logic             run,
  input  logic             stall,
  input  mode_t            mode_q,
  output logic             card_clk,
  output logic             rise,
  output logic [PER_W-1:0] cur_h,
  output logic [PER_W-1:0] cur_l
);
  logic             lvl_q;
  logic [PER_W-1:0] cnt_q, cur_h_q, cur_l_q;
  logic [PER_W-1:0] new_per;
  logic             hi_done, lo_done, idle;

  assign new_per = period_of(mode_q);
  assign hi_done = lvl_q && (cnt_q == cur_h_q - PER_W'(1));
  assign idle    = !lvl_q && !run;
  assign lo_done = !lvl_q && run && !stall && (cnt_q == cur_l_q - PER_W'(1));
  assign rise    = lo_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q   <= 1'b0;
      cnt_q   <= '0;
      cur_h_q <= PER_W'(1);
      cur_l_q <= PER_W'(1);
    end else if (srst_stb) begin
      lvl_q   <= 1'b0;
      cnt_q   <= '0;
      cur_h_q <= PER_W'(1);
      cur_l_q <= PER_W'(1);
    end else if (lvl_q) begin
      if (hi_done) begin
        lvl_q <= 1'b0;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + PER_W'(1);
      end
    end else if (idle) begin
      cnt_q   <= '0;
      cur_h_q <= high_len(new_per);
      cur_l_q <= low_len(new_per);
    end else if (stall) begin
      cnt_q <= cnt_q;
    end else if (lo_done) begin
      lvl_q   <= 1'b1;
      cnt_q   <= '0;
      cur_h_q <= high_len(new_per);
      cur_l_q <= low_len(new_per);
    end else begin
      cnt_q <= cnt_q + PER_W'(1);
    end
  end

  assign card_clk = lvl_q;
  assign cur_h    = cur_h_q;
  assign cur_l    = cur_l_q;
endmodule

// File: rtl/sdclk_gen.sv
`timescale 1ns/1ps
module sdclk_gen
  import sdclk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_en_stb,
  input  logic             ctl_dis_stb,
  input  logic             ctl_srst_stb,
  input  logic             mode_we,
  input  logic [DIV_W-1:0] mode_div,
  input  logic             mode_odd,
  input  logic             mode_ext,
  input  logic             mode_rd_guard,
  input  logic             mode_wr_guard,
  input  logic             rx_full,
  input  logic             tx_empty,
  output logic             card_clk,
  output logic             clk_active
);
  mode_t            mode_in, mode_q;
  logic             en_q, stall, rise;
  logic [PER_W-1:0] cur_h, cur_l;

  assign mode_in = '{ext: mode_ext, rd_guard: mode_rd_guard,
                     wr_guard: mode_wr_guard, odd: mode_odd, div: mode_div};

  sdclk_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .en_stb(ctl_en_stb), .dis_stb(ctl_dis_stb),
    .srst_stb(ctl_srst_stb), .mode_we(mode_we), .mode_in(mode_in),
    .en_q(en_q), .mode_q(mode_q)
  );

  sdclk_stall u_stall (
    .en_q(en_q), .mode_q(mode_q), .rx_full(rx_full), .tx_empty(tx_empty),
    .stall(stall), .active(clk_active)
  );

  sdclk_div u_div (
    .clk(clk), .rst_n(rst_n), .srst_stb(ctl_srst_stb), .run(en_q),
    .stall(stall), .mode_q(mode_q), .card_clk(card_clk), .rise(rise),
    .cur_h(cur_h), .cur_l(cur_l)
  );
endmodule

// File: rtl/sdclk_gen_chk.sv
`timescale 1ns/1ps
module sdclk_gen_chk
  import sdclk_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             en_stb,
  input logic             dis_stb,
  input logic             srst_stb,
  input logic             card_clk,
  input logic             clk_active,
  input logic             en_q,
  input logic             stall,
  input logic [PER_W-1:0] cur_h
);
  AST_IDLE_STAYS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !card_clk) |=> !card_clk); // R8
  AST_STALL_HOLDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !card_clk) |=> !card_clk); // R6
  AST_SRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    srst_stb |=> (!card_clk && !clk_active)); // R9
  AST_DISABLE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    dis_stb |=> !en_q); // R8
  AST_ENABLE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (en_stb && !dis_stb && !srst_stb) |=> en_q); // R8
  AST_RATIO_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (card_clk && $past(card_clk)) |-> $stable(cur_h)); // R5
  AST_ACTIVE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    clk_active |-> en_q); // R10
endmodule

bind sdclk_gen sdclk_gen_chk chk_i (
  .clk(clk), .rst_n(rst_n), .en_stb(ctl_en_stb), .dis_stb(ctl_dis_stb),
  .srst_stb(ctl_srst_stb), .card_clk(card_clk), .clk_active(clk_active),
  .en_q(en_q), .stall(stall), .cur_h(cur_h)
);

// File: tb/sdclk_gen_tb.sv
`timescale 1ns/1ps
module sdclk_gen_tb_top;
  logic clk = 0, rst_n = 0;
  logic en_stb = 0, dis_stb = 0, srst_stb = 0, mode_we = 0;
  logic [7:0] m_div_in = 0;
  logic odd_in = 0, ext_in = 0, rdg_in = 0, wrg_in = 0, rx_full = 0, tx_empty = 0;
  logic card_clk, clk_active;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sdclk_gen dut_i (
    .clk(clk), .rst_n(rst_n), .ctl_en_stb(en_stb), .ctl_dis_stb(dis_stb),
    .ctl_srst_stb(srst_stb), .mode_we(mode_we), .mode_div(m_div_in),
    .mode_odd(odd_in), .mode_ext(ext_in), .mode_rd_guard(rdg_in),
    .mode_wr_guard(wrg_in), .rx_full(rx_full), .tx_empty(tx_empty),
    .card_clk(card_clk), .clk_active(clk_active)
  );

  // Reference model state
  int m_en, m_ext, m_div, m_odd, m_rdg, m_wrg, m_clk, m_rem, m_h, m_l;
  // Run-length tracker on the DUT output
  int prev_lvl = 0, run_len = 0, last_hi = 0, last_lo = 0, toggles = 0;

  function automatic int ref_period(int ext, int dv, int od);
    if (ext != 0) return dv * 2 + od + 2;
    return (dv + 1) * 2;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_en = 0; m_ext = 0; m_div = 0; m_odd = 0; m_rdg = 0; m_wrg = 0;
    m_clk = 0; m_h = 1; m_l = 1; m_rem = 1;
  endtask

  always @(posedge clk) begin
    int per;
    bit st;
    if (!rst_n) model_reset();
    else if (srst_stb) model_reset();
    else begin
      st = (m_en != 0) && ((m_rdg != 0 && rx_full) || (m_wrg != 0 && tx_empty));
      if (m_clk != 0) begin
        if (m_rem <= 1) begin m_clk = 0; m_rem = m_l; end
        else m_rem--;
      end else if (m_en == 0) begin
        per = ref_period(m_ext, m_div, m_odd);
        m_h = (per + 1) / 2; m_l = per / 2; m_rem = m_l;
      end else if (!st) begin
        if (m_rem <= 1) begin
          per = ref_period(m_ext, m_div, m_odd);
          m_h = (per + 1) / 2; m_l = per / 2;
          m_clk = 1; m_rem = m_h;
        end else m_rem--;
      end
      if (dis_stb) m_en = 0;
      else if (en_stb) m_en = 1;
      if (mode_we) begin
        m_ext = ext_in; m_div = m_div_in; m_odd = odd_in;
        m_rdg = rdg_in; m_wrg = wrg_in;
      end
    end
    #2;
    if (rst_n) begin
      // R10: activity flag follows enable and guards
      chk(card_clk == m_clk, "R2/R3/R4 card_clk model", card_clk, m_clk);
      chk(clk_active == ((m_en != 0) && !((m_rdg != 0 && rx_full) || (m_wrg != 0 && tx_empty))),
          "R10 clk_active model", clk_active, m_en);
      if (card_clk == prev_lvl) run_len++;
      else begin
        if (prev_lvl != 0) last_hi = run_len; else last_lo = run_len;
        run_len = 1; toggles++;
      end
      prev_lvl = card_clk;
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_en();  @(negedge clk); en_stb = 1;  @(negedge clk); en_stb = 0;  endtask
  task automatic pulse_dis(); @(negedge clk); dis_stb = 1; @(negedge clk); dis_stb = 0; endtask
  task automatic pulse_srst(); @(negedge clk); srst_stb = 1; @(negedge clk); srst_stb = 0; endtask

  task automatic write_mode(int ext, int dv, int od, int rg, int wg);
    @(negedge clk);
    ext_in = ext[0]; m_div_in = dv[7:0]; odd_in = od[0]; rdg_in = rg[0]; wrg_in = wg[0];
    mode_we = 1;
    @(negedge clk);
    mode_we = 0;
  endtask

  task automatic wait_level(bit lvl);
    do @(negedge clk); while (card_clk != lvl);
  endtask

  initial begin
    while (!done && cycles < 150000) begin @(posedge clk); cycles++; end
    if (!done) begin
      chk(0, "watchdog", cycles, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int t0;
    cyc(3);
    rst_n = 1;
    cyc(2);
    chk(card_clk == 0, "R1 reset card_clk", card_clk, 0);
    chk(clk_active == 0, "R1 reset clk_active", clk_active, 0);
    cyc(20);
    chk(toggles == 0, "R1 no toggles before enable", toggles, 0);

    // R2 R3: extended D=7 -> period 9, high 5, low 4
    write_mode(1, 3, 1, 0, 0);
    pulse_en();
    cyc(40);
    chk(last_hi == 5, "R3 ext D=7 high", last_hi, 5);
    chk(last_lo == 4, "R3 ext D=7 low", last_lo, 4);
    // R2: extended D=0 -> period 2
    write_mode(1, 0, 0, 0, 0);
    cyc(20);
    chk(last_hi + last_lo == 2, "R2 ext D=0 period", last_hi + last_lo, 2);
    // R2 R3: D=511 -> 513 = 257 + 256
    write_mode(1, 255, 1, 0, 0);
    cyc(1100);
    chk(last_hi == 257, "R3 ext D=511 high", last_hi, 257);
    chk(last_lo == 256, "R3 ext D=511 low", last_lo, 256);
    // R4: legacy div=2 with odd set -> 6 = 3 + 3
    write_mode(0, 2, 1, 0, 0);
    cyc(1100);
    chk(last_hi == 3 && last_lo == 3, "R4 legacy div=2 odd ignored", last_hi * 10 + last_lo, 33);

    // R5: change during high phase, current period keeps old ratio
    wait_level(1);
    write_mode(0, 5, 0, 0, 0);
    wait_level(0);
    chk(last_hi == 3, "R5 old high kept", last_hi, 3);
    wait_level(1);
    wait_level(0);
    chk(last_hi == 6, "R5 new high applied", last_hi, 6);

    // R6: read guard
    write_mode(1, 1, 0, 1, 0);
    @(negedge clk); rx_full = 1;
    cyc(30);
    chk(card_clk == 0, "R6 held low on rx_full", card_clk, 0);
    chk(clk_active == 0, "R6 inactive on rx_full", clk_active, 0);
    t0 = toggles;
    write_mode(1, 1, 0, 0, 0);
    cyc(30);
    chk(toggles > t0, "R6 rx_full ignored without guard", toggles - t0, 1);
    @(negedge clk); rx_full = 0;

    // R7: write guard
    write_mode(1, 2, 1, 0, 1);
    @(negedge clk); tx_empty = 1;
    cyc(30);
    t0 = toggles;
    cyc(20);
    chk(toggles == t0 && card_clk == 0, "R7 held low on tx_empty", toggles - t0, 0);
    @(negedge clk); tx_empty = 0;
    cyc(30);
    chk(toggles > t0, "R7 resumes after tx_empty clears", toggles - t0, 1);
    write_mode(1, 2, 1, 0, 0);
    @(negedge clk); tx_empty = 1;
    t0 = toggles;
    cyc(30);
    chk(toggles > t0, "R7 tx_empty ignored without guard", toggles - t0, 1);
    @(negedge clk); tx_empty = 0;

    // R8: disable stops the clock low
    pulse_dis();
    cyc(20);
    t0 = toggles;
    cyc(20);
    chk(toggles == t0 && card_clk == 0, "R8 disabled stays low", toggles - t0, 0);
    // R8: simultaneous strobes -> disabled
    @(negedge clk); en_stb = 1; dis_stb = 1;
    @(negedge clk); en_stb = 0; dis_stb = 0;
    cyc(20);
    chk(toggles == t0 && clk_active == 0, "R8 disable wins", toggles - t0, 0);

    // R9: soft reset while running, then re-enable without rewrite -> period 2
    write_mode(1, 4, 1, 0, 0);
    pulse_en();
    cyc(25);
    wait_level(1);
    @(negedge clk); srst_stb = 1;
    @(negedge clk); srst_stb = 0;
    chk(card_clk == 0, "R9 clock low after soft reset", card_clk, 0);
    chk(clk_active == 0, "R9 disabled after soft reset", clk_active, 0);
    pulse_en();
    cyc(20);
    chk(last_hi == 1 && last_lo == 1, "R9 mode cleared ratio 2", last_hi * 10 + last_lo, 11);

    cyc(5);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule